// File: doc/BRIEF.md
# Two-Level Hardware Breakpoint Trigger

This block decides when a debug breakpoint has been met. Software loads a 32-bit write-only configuration word that holds two trigger levels. Each level combines single-cycle match strobes from external comparators: one for the program counter, two for the address (low-address match and range match) and seven for data lanes. A level can enable each strobe and can invert it before use.

The first level must fire before the second level is looked at. When the sequence completes, the block pulses a report output every time. Depending on a two-bit response field, it can also pulse a halt request or a debug interrupt request. A four-bit status output shows how far the sequence has progressed. After completion the block does nothing more until it is configured again. Any configuration write restarts the sequence from the start.

Top module: `bkpt_trigger`

## Requirements
- R1: After reset, `trig_status` is 0 (idle), and `trig_report`, `halt_req` and `dbg_irq` are low.
- R2: A configuration write clears the status. From the next cycle the status is 1 (armed) if bit 13, the first-level enable, was set, and 0 (idle) otherwise. While idle, no strobe causes a trigger.
- R3: Each level's field uses this bit layout, with level 1 in bits 12:0 and level 2 in bits 28:16. Field bits 12:6 enable `data_match[6:0]` (field bit 6+i enables lane i). Bit 5 inverts data. Bit 4 inverts address. Bit 3 enables the range match. Bit 2 enables the low-address match. Bit 1 enables the PC match. Bit 0 inverts PC. A level fires in a cycle when the OR of its enabled, qualified strobes is 1. Strobes that are not enabled have no effect.
- R4: An invert bit complements its strobe before the strobe is qualified, so an enabled, inverted strobe fires when that strobe is low.
- R5: Bit 29 enables level 2. When it is set, a level-1 fire moves the status to 2 (first level hit). Level 2 is evaluated only from the following cycle; level-2 strobes in the same cycle as the level-1 fire are ignored. A later level-2 fire sets the status to 3 (second level hit) and completes the trigger.
- R6: When bit 29 is clear, a level-1 fire alone completes the trigger, and the status becomes 2.
- R7: On the clock edge that completes the trigger, `trig_report` goes high for exactly one cycle for every response code. Bits 31:30 select the response: 01 also pulses `halt_req`, 10 also pulses `dbg_irq`, and 00 and 11 pulse neither.
- R8: After completion, the status holds its final value and no further response is issued until the next configuration write.
- R9: Reserved bits 15:14 of the configuration word have no effect on behaviour.
- R10: A configuration write in the same cycle as a qualifying strobe takes priority. No response is issued, and the status reflects the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| pc_match | input | 1 | Program-counter comparator strobe |
| addr_lo_match | input | 1 | Low-address comparator strobe |
| addr_rng_match | input | 1 | Address-range comparator strobe |
| data_match | input | 7 | Data lane comparator strobes |
| trig_status | output | 4 | Sequence status: 0 idle, 1 armed, 2 first hit, 3 second hit |
| trig_report | output | 1 | One-cycle pulse on every completed trigger |
| halt_req | output | 1 | One-cycle processor halt request |
| dbg_irq | output | 1 | One-cycle debug interrupt request |

## Verification
The status is a registered output, so a wrong sequence state shows at `trig_status` one cycle after the strobe or write that caused it. Examples are advancing on a disabled strobe, looking at level 2 too early, or failing to rearm after a write. A wrong completion decision or response decode shows in the same cycle on `trig_report`, `halt_req` and `dbg_irq`. A stuck active flag shows as a second report pulse on a later strobe. The bench therefore checks the status after every stimulus cycle and checks the three pulse outputs both in the completion cycle and in the cycle after it.

// File: rtl/bkpt_trigger.sv
module bkpt_trigger #(
  parameter int CFG_W  = 32,
  parameter int LANES  = 7,
  parameter int STS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             pc_match,
  input  logic             addr_lo_match,
  input  logic             addr_rng_match,
  input  logic [LANES-1:0] data_match,
  output logic [STS_W-1:0] trig_status,
  output logic             trig_report,
  output logic             halt_req,
  output logic             dbg_irq
);

  localparam int FLD_W = LANES + 6;
  localparam int L2_LO = CFG_W / 2;
  localparam logic [STS_W-1:0] ST_IDLE  = STS_W'(0);
  localparam logic [STS_W-1:0] ST_ARMED = STS_W'(1);
  localparam logic [STS_W-1:0] ST_HIT1  = STS_W'(2);
  localparam logic [STS_W-1:0] ST_HIT2  = STS_W'(3);

  logic [FLD_W-1:0] fld1, fld2;
  logic             en2, active;
  logic [1:0]       resp;
  logic             fire1, fire2, done;

  function automatic logic lvl_fires(input logic [FLD_W-1:0] f, input logic pc,
                                     input logic lo, input logic rng,
                                     input logic [LANES-1:0] d);
    lvl_fires = (f[1] & (pc ^ f[0]))
              | (f[2] & (lo ^ f[4]))
              | (f[3] & (rng ^ f[4]))
              | (|(f[FLD_W-1:6] & (d ^ {LANES{f[5]}})));
  endfunction

  assign fire1 = lvl_fires(fld1, pc_match, addr_lo_match, addr_rng_match, data_match);
  assign fire2 = lvl_fires(fld2, pc_match, addr_lo_match, addr_rng_match, data_match);
  assign done  = !cfg_wr && active &&
                 (((trig_status == ST_ARMED) && fire1 && !en2) ||
                  ((trig_status == ST_HIT1) && fire2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld1 <= '0;
      fld2 <= '0;
      en2 <= 1'b0;
      resp <= 2'b00;
      active <= 1'b0;
      trig_status <= ST_IDLE;
      trig_report <= 1'b0;
      halt_req <= 1'b0;
      dbg_irq <= 1'b0;
    end else begin
      trig_report <= done;
      halt_req <= done && (resp == 2'b01);
      dbg_irq <= done && (resp == 2'b10);
      if (cfg_wr) begin
        resp <= cfg_wdata[CFG_W-1 -: 2];
        en2 <= cfg_wdata[L2_LO+FLD_W];
        fld2 <= cfg_wdata[L2_LO +: FLD_W];
        fld1 <= cfg_wdata[FLD_W-1:0];
        active <= cfg_wdata[FLD_W];
        trig_status <= cfg_wdata[FLD_W] ? ST_ARMED : ST_IDLE;
      end else if (active) begin
        if (trig_status == ST_ARMED && fire1) begin
          trig_status <= ST_HIT1;
          if (!en2) active <= 1'b0;
        end else if (trig_status == ST_HIT1 && fire2) begin
          trig_status <= ST_HIT2;
          active <= 1'b0;
        end
      end
    end
  end

  AST_HALT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) halt_req |=> !halt_req); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) dbg_irq |=> !dbg_irq); // R7
  AST_REQ_WITH_REPORT: assert property (@(posedge clk) disable iff (!rst_n) (halt_req || dbg_irq) |-> (trig_report && !(halt_req && dbg_irq))); // R7
  AST_REPORT_ONCE: assert property (@(posedge clk) disable iff (!rst_n) trig_report |=> !trig_report); // R8
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) cfg_wr |=> (!trig_report && trig_status <= ST_ARMED)); // R10
  AST_L2_AFTER_L1: assert property (@(posedge clk) disable iff (!rst_n) (trig_status == ST_HIT2 && $past(trig_status) != ST_HIT2) |-> $past(trig_status) == ST_HIT1); // R5

endmodule

// File: tb/bkpt_trigger_tb.sv
module bkpt_trigger_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        pc_match = 1'b0, addr_lo_match = 1'b0, addr_rng_match = 1'b0;
  logic [6:0]  data_match = '0;
  logic [3:0]  trig_status;
  logic        trig_report, halt_req, dbg_irq;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  localparam logic [12:0] F_PCI = 13'h001, F_PCE = 13'h002, F_ALO = 13'h004,
                          F_ARG = 13'h008, F_AIN = 13'h010, F_DIN = 13'h020;

  always #4 clk = ~clk;

  bkpt_trigger u_dut (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .pc_match(pc_match), .addr_lo_match(addr_lo_match), .addr_rng_match(addr_rng_match),
    .data_match(data_match), .trig_status(trig_status), .trig_report(trig_report),
    .halt_req(halt_req), .dbg_irq(dbg_irq));

  function automatic logic [12:0] lane(input int i);
    return 13'(1) << (6 + i);
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] rs, input logic e2, input logic [12:0] f2,
                                     input logic e1, input logic [12:0] f1);
    return {rs, e2, f2, 2'b00, e1, f1};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int st, input logic rep, input logic hl, input logic iq);
    chk({req, " status"}, 32'(trig_status), 32'(st));
    chk({req, " report"}, 32'(trig_report), 32'(rep));
    chk({req, " halt"}, 32'(halt_req), 32'(hl));
    chk({req, " irq"}, 32'(dbg_irq), 32'(iq));
  endtask

  task automatic wr(input logic [31:0] w);
    cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic strobe(input logic pc, input logic lo, input logic rng, input logic [6:0] d);
    pc_match = pc; addr_lo_match = lo; addr_rng_match = rng; data_match = d;
    @(negedge clk);
    pc_match = 0; addr_lo_match = 0; addr_rng_match = 0; data_match = '0;
  endtask

  task automatic t_reset;
    chk_out("R1", 0, 0, 0, 0);
  endtask

  task automatic t_disabled;
    wr(mk(2'b01, 1'b1, 13'h1FFF, 1'b0, 13'h1FFF));
    chk_out("R2 disabled", 0, 0, 0, 0);
    strobe(1, 1, 1, 7'h7F);
    chk_out("R2 idle strobes", 0, 0, 0, 0);
  endtask

  task automatic t_pc_only;
    wr(mk(2'b01, 1'b0, 13'h0, 1'b1, F_PCE));
    chk_out("R2 armed", 1, 0, 0, 0);
    strobe(0, 1, 1, 7'h7F);
    chk_out("R3 unenabled", 1, 0, 0, 0);
    strobe(1, 0, 0, 7'h00);
    chk_out("R6 R7 halt", 2, 1, 1, 0);
    @(negedge clk);
    chk_out("R7 pulse end", 2, 0, 0, 0);
    strobe(1, 0, 0, 7'h00);
    chk_out("R8 held", 2, 0, 0, 0);
    wr(mk(2'b00, 1'b0, 13'h0, 1'b0, F_PCE));
    chk_out("R2 clear", 0, 0, 0, 0);
  endtask

  task automatic t_two_level;
    wr(mk(2'b10, 1'b1, lane(3), 1'b1, F_ALO));
    strobe(0, 1, 0, 7'h08);
    chk_out("R5 same cycle", 2, 0, 0, 0);
    strobe(0, 0, 0, 7'h04);
    chk_out("R3 wrong lane", 2, 0, 0, 0);
    strobe(0, 0, 0, 7'h08);
    chk_out("R5 R7 irq", 3, 1, 0, 1);
    @(negedge clk);
    chk_out("R8 after L2", 3, 0, 0, 0);
  endtask

  task automatic t_invert;
    pc_match = 1'b1;
    wr(mk(2'b00, 1'b0, 13'h0, 1'b1, F_PCE | F_PCI));
    @(negedge clk);
    chk_out("R4 pc held high", 1, 0, 0, 0);
    pc_match = 1'b0;
    @(negedge clk);
    chk_out("R4 R7 pc inverted", 2, 1, 0, 0);
    addr_rng_match = 1'b1;
    wr(mk(2'b00, 1'b0, 13'h0, 1'b1, F_ARG | F_AIN));
    @(negedge clk);
    chk_out("R4 rng held", 1, 0, 0, 0);
    addr_rng_match = 1'b0;
    @(negedge clk);
    chk_out("R4 rng inverted", 2, 1, 0, 0);
    data_match = 7'h7F;
    wr(mk(2'b01, 1'b0, 13'h0, 1'b1, lane(0) | F_DIN));
    @(negedge clk);
    chk_out("R4 data held", 1, 0, 0, 0);
    data_match = 7'h7E;
    @(negedge clk);
    chk_out("R4 data inverted", 2, 1, 1, 0);
    data_match = '0;
  endtask

  task automatic t_reserved;
    wr(mk(2'b11, 1'b0, 13'h0, 1'b1, F_PCE) | 32'h0000_C000);
    chk_out("R9 armed", 1, 0, 0, 0);
    strobe(1, 0, 0, 7'h00);
    chk_out("R9 R7 code11", 2, 1, 0, 0);
  endtask

  task automatic t_priority;
    wr(mk(2'b01, 1'b0, 13'h0, 1'b1, F_PCE));
    pc_match = 1'b1;
    wr(mk(2'b10, 1'b0, 13'h0, 1'b1, F_ALO));
    pc_match = 1'b0;
    chk_out("R10 write wins", 1, 0, 0, 0);
    strobe(0, 1, 0, 7'h00);
    chk_out("R10 new cfg", 2, 1, 0, 1);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_disabled;
    t_pc_only;
    t_two_level;
    t_invert;
    t_reserved;
    t_priority;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule